// File: doc/BRIEF.md
# Decode-Stage Read-After-Write Interlock

This block guards the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no operand bypass paths. Each cycle it compares the two source register numbers of the instruction sitting in decode against the destination registers of the three older instructions in execute, memory and writeback. If a source the instruction actually reads will still be written by one of them, the block holds the front end and lets the back end keep moving until the value has reached the register file.

Whether each source is read comes from a small class decode of the decode-stage instruction. While a hazard is present, the program counter and the fetch/decode register are told not to load, so the waiting instruction stays in decode. The control bits heading into the decode/execute register are forced to zero at the same time, so a harmless bubble enters execute. Execute, memory and writeback are never held, so the producing instruction keeps draining toward writeback. The block is purely combinational: the stall takes effect in the same cycle the hazard appears.

Top module: `raw_interlock`

## Requirements
- R1: `stall` is high when a used source of the decode instruction equals the destination of a write-enabled instruction in any one of execute, memory or writeback. Each stage is checked on its own, and each source is checked on its own.
- R2: The 3-bit `dec_cls` code selects which sources are read:
  - 0 register-register ALU: both.
  - 1 immediate ALU: `dec_rs` only.
  - 2 load: `dec_rs` only.
  - 3 store: both.
  - 4 conditional branch: both.
  - 5 register jump: `dec_rs` only.
  - 6 plain jump: neither.
  - 7 no-op: neither.

  A match on a source that is not read never raises `stall`.
- R3: A stage whose write-enable is low, or whose destination is register 0, is never a producer and never raises `stall`.
- R4: A source equal to register 0 never raises `stall`.
- R5: When no write-enabled producer in the three stages matches a read source, `stall` is low. An instruction therefore goes ahead as soon as its producer has left writeback.
- R6: `pc_we` and `ifid_we` are both low while `stall` is high, and both high otherwise.
- R7: `dec_ctl` holds register write in bit 0, memory read in bit 1 and memory write in bit 2. While `stall` is high, `idex_bubble` is high and `idex_ctl` is all zero. Otherwise `idex_bubble` is low and `idex_ctl` equals `dec_ctl`.
- R8: In a pipeline whose back end advances every cycle, a consumer that directly follows a producer loses 3 cycles. With one instruction between them it loses 2, with two between it loses 1, and with three or more between it loses none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_cls | input | 3 | Class code of the decode instruction (R2) |
| dec_rs | input | REG_W | First source register number |
| dec_rt | input | REG_W | Second source register number |
| dec_ctl | input | 3 | Decode control bits: write, mem read, mem write |
| ex_dst | input | REG_W | Destination of the execute instruction |
| ex_we | input | 1 | Register write-enable of the execute instruction |
| mem_dst | input | REG_W | Destination of the memory instruction |
| mem_we | input | 1 | Register write-enable of the memory instruction |
| wb_dst | input | REG_W | Destination of the writeback instruction |
| wb_we | input | 1 | Register write-enable of the writeback instruction |
| stall | output | 1 | Hazard present, front end held |
| pc_we | output | 1 | Program counter load enable |
| ifid_we | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Inject a bubble into execute |
| idex_ctl | output | 3 | Control bits for the decode/execute register |

## Verification
Immediate assertions in the design watch every evaluation for the following:
- No stall comes from a plain jump, a no-op, or a pair of zero sources.
- A stall always has a live producer behind it.
- A stall always comes with a frozen front end and an all-zero control word into execute.

Directed bench scenarios cover what the assertions cannot show:
- Each stage is detected separately for each source.
- A match on a source that is not read is masked.
- A disabled producer, or one writing register 0, is ignored.
- A bench pipeline shell drains the back end behind a held decode stage and shows stall counts of 3, 2, 1 and 0 as the producer-consumer gap grows.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int CLS_W = 3;
    localparam int CTL_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU_RR = 3'd0,
        CLS_ALU_RI = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4,
        CLS_JREG   = 3'd5,
        CLS_JUMP   = 3'd6,
        CLS_NOP    = 3'd7
    } ins_cls_e;

    typedef struct packed {
        logic rd_a;
        logic rd_b;
    } src_use_t;

endpackage

// File: rtl/ilk_use_decode.sv
module ilk_use_decode
    import ilk_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output src_use_t         uses
);
    always_comb begin
        uses = '0;
        unique case (ins_cls_e'(cls))
            CLS_ALU_RR: uses = '{rd_a: 1'b1, rd_b: 1'b1};
            CLS_ALU_RI: uses = '{rd_a: 1'b1, rd_b: 1'b0};
            CLS_LOAD:   uses = '{rd_a: 1'b1, rd_b: 1'b0};
            CLS_STORE:  uses = '{rd_a: 1'b1, rd_b: 1'b1};
            CLS_BRANCH: uses = '{rd_a: 1'b1, rd_b: 1'b1};
            CLS_JREG:   uses = '{rd_a: 1'b1, rd_b: 1'b0};
            CLS_JUMP:   uses = '{rd_a: 1'b0, rd_b: 1'b0};
            CLS_NOP:    uses = '{rd_a: 1'b0, rd_b: 1'b0};
            default:    uses = '0;
        endcase
    end
endmodule

// File: rtl/ilk_src_match.sv
module ilk_src_match #(
    parameter int REG_W  = 5,
    parameter int N_PROD = 3
) (
    input  logic [REG_W-1:0]             src,
    input  logic                         rd_en,
    input  logic [N_PROD-1:0][REG_W-1:0] prod_dst,
    input  logic [N_PROD-1:0]            prod_we,
    output logic                         hit
);
    logic [N_PROD-1:0] stage_hit;
    logic              src_live;

    assign src_live = rd_en && (src != '0);

    for (genvar g = 0; g < N_PROD; g++) begin : g_stage
        logic live_prod;
        assign live_prod    = prod_we[g] && (prod_dst[g] != '0);
        assign stage_hit[g] = live_prod && (prod_dst[g] == src);
    end

    assign hit = src_live && (|stage_hit);
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
    import ilk_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [CLS_W-1:0] dec_cls,
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic [CTL_W-1:0] dec_ctl,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_we,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output logic             stall,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble,
    output logic [CTL_W-1:0] idex_ctl
);
    localparam int N_PROD = 3;

    // Stage order: index 0 execute, 1 memory, 2 writeback.
    logic [N_PROD-1:0][REG_W-1:0] p_dst;
    logic [N_PROD-1:0]            p_we;
    src_use_t                     uses;
    logic                         hit_a;
    logic                         hit_b;

    assign p_dst = {wb_dst, mem_dst, ex_dst};
    assign p_we  = {wb_we, mem_we, ex_we};

    ilk_use_decode u_dec (
        .cls  (dec_cls),
        .uses (uses)
    );

    ilk_src_match #(.REG_W(REG_W), .N_PROD(N_PROD)) u_match_a (
        .src      (dec_rs),
        .rd_en    (uses.rd_a),
        .prod_dst (p_dst),
        .prod_we  (p_we),
        .hit      (hit_a)
    );

    ilk_src_match #(.REG_W(REG_W), .N_PROD(N_PROD)) u_match_b (
        .src      (dec_rt),
        .rd_en    (uses.rd_b),
        .prod_dst (p_dst),
        .prod_we  (p_we),
        .hit      (hit_b)
    );

    always_comb begin
        stall       = hit_a || hit_b;
        pc_we       = !stall;
        ifid_we     = !stall;
        idex_bubble = stall;
        idex_ctl    = stall ? '0 : dec_ctl;
    end

    always_comb begin
        // R2: plain jumps and no-ops read nothing, so they can never wait.
        a_r2_no_read_no_wait: assert (!(((dec_cls == CLS_JUMP) || (dec_cls == CLS_NOP)) && stall))
            else $error("R2 stall raised by an instruction that reads no register");
        // R4: two zero sources can never wait.
        a_r4_zero_sources: assert (!((dec_rs == '0) && (dec_rt == '0) && stall))
            else $error("R4 stall raised with both sources equal to register 0");
        // R3: a stall needs at least one live producer downstream.
        a_r3_live_producer: assert (!stall ||
                                    (ex_we && ex_dst != '0) ||
                                    (mem_we && mem_dst != '0) ||
                                    (wb_we && wb_dst != '0))
            else $error("R3 stall raised without any live producer");
        // R6: front end holds together during a stall.
        a_r6_front_hold: assert (!stall || (!pc_we && !ifid_we))
            else $error("R6 front end still loading during a stall");
        // R7: bubble carries no write or memory action.
        a_r7_clean_bubble: assert (!stall || (idex_bubble && idex_ctl == '0))
            else $error("R7 bubble carries live control bits");
    end
endmodule

// File: tb/sim_raw_interlock.sv
module sim_raw_interlock;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic [2:0]    cls;
    logic [RW-1:0] rs, rt;
    logic [2:0]    ctl;
    logic [RW-1:0] exd, md, wd;
    logic          exw, mw, ww;
    logic          stall, pc_we, ifid_we, bub;
    logic [2:0]    ictl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    raw_interlock #(.REG_W(RW)) u0 (
        .dec_cls(cls), .dec_rs(rs), .dec_rt(rt), .dec_ctl(ctl),
        .ex_dst(exd), .ex_we(exw), .mem_dst(md), .mem_we(mw),
        .wb_dst(wd), .wb_we(ww),
        .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we),
        .idex_bubble(bub), .idex_ctl(ictl)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_id(input logic [2:0] c, input int a, input int b, input logic [2:0] k);
        cls = c; rs = RW'(a); rt = RW'(b); ctl = k;
    endtask

    task automatic set_prod(input int e, input logic ew, input int m, input logic mwe,
                            input int w, input logic wwe);
        exd = RW'(e); exw = ew; md = RW'(m); mw = mwe; wd = RW'(w); ww = wwe;
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    task automatic t_idle;
        set_id(3'd7, 0, 0, 3'b000);
        set_prod(0, 0, 0, 0, 0, 0);
        settle();
        check("R5 idle stall", stall, 0);
        check("R6 idle pc_we", pc_we, 1);
        check("R6 idle ifid_we", ifid_we, 1);
        check("R7 idle bubble", bub, 0);
    endtask

    task automatic t_each_stage;
        set_id(3'd0, 9, 12, 3'b001);
        set_prod(9, 1, 0, 0, 0, 0); settle();
        check("R1 rs vs execute", stall, 1);
        set_prod(0, 0, 9, 1, 0, 0); settle();
        check("R1 rs vs memory", stall, 1);
        set_prod(0, 0, 0, 0, 9, 1); settle();
        check("R1 rs vs writeback", stall, 1);
        set_prod(12, 1, 0, 0, 0, 0); settle();
        check("R1 rt vs execute", stall, 1);
        set_prod(0, 0, 12, 1, 0, 0); settle();
        check("R1 rt vs memory", stall, 1);
        set_prod(0, 0, 0, 0, 12, 1); settle();
        check("R1 rt vs writeback", stall, 1);
        set_prod(3, 1, 4, 1, 8, 1); settle();
        check("R5 unrelated producers", stall, 0);
    endtask

    task automatic t_use_flags;
        set_prod(12, 1, 0, 0, 0, 0);
        set_id(3'd1, 9, 12, 3'b001); settle();
        check("R2 immediate ALU ignores rt", stall, 0);
        set_id(3'd2, 9, 12, 3'b011); settle();
        check("R2 load ignores rt", stall, 0);
        set_id(3'd5, 9, 12, 3'b000); settle();
        check("R2 register jump ignores rt", stall, 0);
        set_id(3'd3, 9, 12, 3'b100); settle();
        check("R2 store reads rt", stall, 1);
        set_id(3'd4, 9, 12, 3'b000); settle();
        check("R2 branch reads rt", stall, 1);
        set_prod(9, 1, 12, 1, 0, 0);
        set_id(3'd6, 9, 12, 3'b000); settle();
        check("R2 plain jump reads nothing", stall, 0);
        set_id(3'd7, 9, 12, 3'b000); settle();
        check("R2 no-op reads nothing", stall, 0);
        set_id(3'd5, 9, 12, 3'b000); settle();
        check("R2 register jump reads rs", stall, 1);
    endtask

    task automatic t_producer_gate;
        set_id(3'd0, 9, 12, 3'b001);
        set_prod(9, 0, 9, 0, 12, 0); settle();
        check("R3 write-enable low ignored", stall, 0);
        set_id(3'd0, 0, 0, 3'b001);
        set_prod(0, 1, 0, 1, 0, 1); settle();
        check("R3 R4 register 0 never waits", stall, 0);
        set_id(3'd3, 0, 7, 3'b100);
        set_prod(0, 1, 0, 1, 0, 1); settle();
        check("R3 dest 0 not a producer", stall, 0);
        set_prod(7, 1, 0, 0, 0, 0); settle();
        check("R4 nonzero rt still checked", stall, 1);
    endtask

    task automatic t_front_and_bubble;
        set_id(3'd2, 5, 0, 3'b011);
        set_prod(0, 0, 0, 0, 0, 0); settle();
        check("R7 control passes when clear", ictl, 3'b011);
        check("R7 no bubble when clear", bub, 0);
        set_prod(0, 0, 5, 1, 0, 0); settle();
        check("R6 pc_we low on stall", pc_we, 0);
        check("R6 ifid_we low on stall", ifid_we, 0);
        check("R7 bubble on stall", bub, 1);
        check("R7 control zero on stall", ictl, 0);
        set_id(3'd3, 5, 6, 3'b100); settle();
        check("R7 store write bit cleared", ictl, 0);
    endtask

    // Pipeline shell: the back end advances every cycle, decode holds on stall.
    task automatic t_distance(input int k, input int exp_stalls);
        logic [2:0]    p_cls [0:7];
        logic [RW-1:0] p_rs [0:7], p_rt [0:7], p_dst [0:7];
        logic          p_we [0:7];
        int n, pc, stalls, cyc;
        logic s;
        for (int i = 0; i < 8; i++) begin
            p_cls[i] = 3'd1; p_rs[i] = RW'(1); p_rt[i] = '0;
            p_dst[i] = RW'(20 + i); p_we[i] = 1'b1;
        end
        p_cls[0] = 3'd0; p_rs[0] = RW'(1); p_rt[0] = RW'(2); p_dst[0] = RW'(5);
        p_cls[k] = 3'd0; p_rs[k] = RW'(6); p_rt[k] = RW'(5); p_dst[k] = RW'(7);
        n = k + 1; pc = 0; stalls = 0; cyc = 0;
        set_prod(0, 0, 0, 0, 0, 0);
        while (pc < n && cyc < 40) begin
            set_id(p_cls[pc], int'(p_rs[pc]), int'(p_rt[pc]), 3'b001);
            @(negedge clk);
            s = stall;
            if (s) stalls++;
            @(posedge clk);
            #1;
            wd = md; ww = mw;
            md = exd; mw = exw;
            if (!s) begin
                exd = p_dst[pc]; exw = p_we[pc]; pc++;
            end else begin
                exd = '0; exw = 1'b0;
            end
            cyc++;
        end
        check($sformatf("R8 stalls at gap %0d", k), stalls, exp_stalls);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_id(3'd7, 0, 0, 3'b000);
        set_prod(0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        t_idle();
        t_each_stage();
        t_use_flags();
        t_producer_gate();
        t_front_and_bubble();
        t_distance(1, 3);
        t_distance(2, 2);
        t_distance(3, 1);
        t_distance(4, 0);
        t_distance(5, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule